// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to 32 level-sensitive request lines and software-raised interrupt numbers. It presents the single most urgent one that is not masked to a simple CPU sequencer. The line index is the priority level, and a higher number is more urgent. System software places events on fixed levels: scheduler work on 2, general devices on 3 through 26, performance monitoring on 27, the clock tick on 28, inter-processor signalling on 29 and power events on 30.

For the presented request, the block gives the handler address and the return address. The handler address is a vector table base plus four times the level. The return address is the current program counter plus four.

When the sequencer accepts a request, the level is pushed onto a small in-service stack together with the processor mode that was active. The mode then switches to kernel. While a level is in service, only strictly higher levels may preempt it. An end-of-interrupt strobe pops the stack. This restores both the previous service level, which sets the mask, and the previous processor mode.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, no request is presented, nothing is in service, the mode is user (`mode_kernel` = 0), and no software request is pending.
- R2: Each request line is sampled on every clock. Bit i of `irq_lines` is a request at level i, and it can be presented in the cycle after it is sampled. A line that is masked is not lost: it is presented once the mask allows it, for as long as it is still held.
- R3: Among the pending levels that are not masked, the numerically highest is presented on `irq_level` with `irq_req` = 1.
- R4: While level s is in service (the top of the stack), only pending levels strictly greater than s are presented. With nothing in service, every level is eligible.
- R5: `vec_addr` equals `base_addr` + 4 × `irq_level`, modulo 2^32.
- R6: `ret_addr` equals `cur_pc` + 4, modulo 2^32.
- R7: When `take` is high while `irq_req` is high, the presented level becomes the service level in the next cycle and `mode_kernel` becomes 1. Up to 4 levels nest. While 4 are in service, no request is presented.
- R8: `eoi` while something is in service removes the top level. In the next cycle the previous level is back in service (or nothing is), the mask follows that level, and `mode_kernel` returns to the value it had before the removed level was entered.
- R9: `eoi` while nothing is in service has no effect.
- R10: `take` while `irq_req` is low has no effect.
- R11: `swi_valid` with `swi_num` = n makes level n pending from the next cycle on. It stays pending until level n is taken. If a new software request for the same level arrives in the cycle it is taken, the new request is kept.
- R12: When `take` (with `irq_req`) and `eoi` fall in the same cycle, the pop is applied first and the push second. The nesting depth is unchanged, the new level replaces the old top, and the mode saved for the new level is the mode that the pop restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one instruction boundary |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | Level-sensitive request lines; bit index is the level |
| swi_valid | input | 1 | Software interrupt strobe |
| swi_num | input | 5 | Level raised by the software interrupt |
| base_addr | input | 32 | Vector table base address |
| cur_pc | input | 32 | Program counter of the interrupted instruction |
| take | input | 1 | Sequencer accepts the presented request |
| eoi | input | 1 | End of interrupt from the handler |
| irq_req | output | 1 | A request is presented |
| irq_level | output | 5 | Level of the presented request |
| vec_addr | output | 32 | Handler address of the presented level |
| ret_addr | output | 32 | Return address to save |
| mode_kernel | output | 1 | Current processor mode, 1 = kernel |
| svc_active | output | 1 | At least one level is in service |
| svc_level | output | 5 | Level currently in service (0 when idle) |

## Verification
The collision of interest is an acceptance and an end-of-interrupt strobe in the same cycle. That cycle both retires the current level and enters a new one, so the stack order and the saved mode must come out as pop-then-push. A directed sequence fills the stack, retires the top level so that a higher line is presented, and then raises `take` and `eoi` together. A long random phase drives both strobes independently, so the two also meet often with varied depths, software requests and masks. A behavioural model that keeps the stack as a queue predicts every output each cycle, and the bench judges the collision through the visible service level, the mode and the subsequent masking.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   // fixed system level map (bit index of the request vector)
   localparam int unsigned LVL_SCHED    = 2;
   localparam int unsigned LVL_DEV_LO   = 3;
   localparam int unsigned LVL_DEV_HI   = 26;
   localparam int unsigned LVL_PERFMON  = 27;
   localparam int unsigned LVL_TICK     = 28;
   localparam int unsigned LVL_IPI      = 29;
   localparam int unsigned LVL_POWER    = 30;

   // in-service stack operation for one cycle
   typedef enum logic [1:0] {
      STK_HOLD = 2'd0,
      STK_PUSH = 2'd1,
      STK_POP  = 2'd2,
      STK_SWAP = 2'd3
   } stk_op_e;

endpackage

// File: rtl/prio_irq_pend.sv
module prio_irq_pend #(
   parameter int unsigned NUM_LINES = 32,
   localparam int unsigned LVL_W    = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lines_i,
   input  logic                 swi_valid_i,
   input  logic [LVL_W-1:0]     swi_num_i,
   input  logic                 clr_valid_i,
   input  logic [LVL_W-1:0]     clr_num_i,
   output logic [NUM_LINES-1:0] pend_o
);

   logic [NUM_LINES-1:0] samp_q;
   logic [NUM_LINES-1:0] soft_q;
   logic [NUM_LINES-1:0] soft_d;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_soft
      localparam logic [LVL_W-1:0] IDX = LVL_W'(i);
      logic hit_clr;
      logic hit_set;
      assign hit_clr   = clr_valid_i & (clr_num_i == IDX);
      assign hit_set   = swi_valid_i & (swi_num_i == IDX);
      // a fresh software request wins over the clear of the same level
      assign soft_d[i] = (soft_q[i] & ~hit_clr) | hit_set;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         samp_q <= '0;
         soft_q <= '0;
      end else begin
         samp_q <= lines_i;
         soft_q <= soft_d;
      end
   end

   assign pend_o = samp_q | soft_q;

endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick #(
   parameter int unsigned NUM_LINES = 32,
   localparam int unsigned LVL_W    = $clog2(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0] pend_i,
   input  logic                 thr_valid_i,
   input  logic [LVL_W-1:0]     thr_i,
   input  logic                 block_i,
   output logic                 any_o,
   output logic [LVL_W-1:0]     idx_o
);

   logic [NUM_LINES-1:0] elig;
   logic                 any_raw;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_mask
      localparam logic [LVL_W-1:0] IDX = LVL_W'(i);
      assign elig[i] = pend_i[i] & (~thr_valid_i | (IDX > thr_i));
   end

   // last match wins: highest eligible index
   always_comb begin
      any_raw = 1'b0;
      idx_o   = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (elig[i]) begin
            any_raw = 1'b1;
            idx_o   = LVL_W'(i);
         end
      end
   end

   assign any_o = any_raw & ~block_i;

endmodule

// File: rtl/prio_irq_stack.sv
module prio_irq_stack
   import prio_irq_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 32,
   parameter int unsigned STACK_DEPTH = 4,
   localparam int unsigned LVL_W      = $clog2(NUM_LINES),
   localparam int unsigned CNT_W      = $clog2(STACK_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  stk_op_e          op_i,
   input  logic [LVL_W-1:0] lvl_i,
   input  logic             mode_i,
   output logic [LVL_W-1:0] top_lvl_o,
   output logic             top_mode_o,
   output logic             empty_o,
   output logic             full_o
);

   logic [CNT_W-1:0]             cnt_q;
   logic [CNT_W-1:0]             cnt_d;
   logic [CNT_W-1:0]             wr_idx;
   logic                         wr_en;
   logic [STACK_DEPTH*LVL_W-1:0] lvl_flat;
   logic [STACK_DEPTH-1:0]       mode_flat;

   always_comb begin
      wr_en  = 1'b0;
      wr_idx = cnt_q;
      cnt_d  = cnt_q;
      unique case (op_i)
         STK_PUSH: begin
            wr_en = 1'b1;
            cnt_d = cnt_q + CNT_W'(1);
         end
         STK_SWAP: begin
            wr_en  = 1'b1;
            wr_idx = cnt_q - CNT_W'(1);
         end
         STK_POP:  cnt_d = cnt_q - CNT_W'(1);
         default:  cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   for (genvar j = 0; j < STACK_DEPTH; j++) begin : g_slot
      logic [LVL_W-1:0] lvl_q;
      logic             mode_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lvl_q  <= '0;
            mode_q <= 1'b0;
         end else if (wr_en && (wr_idx == CNT_W'(j))) begin
            lvl_q  <= lvl_i;
            mode_q <= mode_i;
         end
      end
      assign lvl_flat[j*LVL_W +: LVL_W] = lvl_q;
      assign mode_flat[j]               = mode_q;
   end

   always_comb begin
      top_lvl_o  = '0;
      top_mode_o = 1'b0;
      for (int j = 0; j < STACK_DEPTH; j++) begin
         if (cnt_q == CNT_W'(j + 1)) begin
            top_lvl_o  = lvl_flat[j*LVL_W +: LVL_W];
            top_mode_o = mode_flat[j];
         end
      end
   end

   assign empty_o = (cnt_q == '0);
   assign full_o  = (cnt_q == CNT_W'(STACK_DEPTH));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 32,
   parameter int unsigned STACK_DEPTH = 4,
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned VEC_SHIFT   = 2,
   parameter int unsigned RET_STEP    = 4,
   localparam int unsigned LVL_W      = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic                 swi_valid,
   input  logic [LVL_W-1:0]     swi_num,
   input  logic [ADDR_W-1:0]    base_addr,
   input  logic [ADDR_W-1:0]    cur_pc,
   input  logic                 take,
   input  logic                 eoi,
   output logic                 irq_req,
   output logic [LVL_W-1:0]     irq_level,
   output logic [ADDR_W-1:0]    vec_addr,
   output logic [ADDR_W-1:0]    ret_addr,
   output logic                 mode_kernel,
   output logic                 svc_active,
   output logic [LVL_W-1:0]     svc_level
);

   // elaboration-time parameter checks
   if (NUM_LINES < 2 || NUM_LINES > 64) begin : g_chk_lines
      $error("prio_irq_ctrl: NUM_LINES must lie in 2..64");
   end
   if (STACK_DEPTH < 1 || STACK_DEPTH > 16) begin : g_chk_depth
      $error("prio_irq_ctrl: STACK_DEPTH must lie in 1..16");
   end
   if (ADDR_W < LVL_W + VEC_SHIFT) begin : g_chk_addr
      $error("prio_irq_ctrl: ADDR_W too narrow for the vector table");
   end

   logic [NUM_LINES-1:0] pend_vec;
   logic                 stk_empty;
   logic                 stk_full;
   logic [LVL_W-1:0]     top_lvl;
   logic                 top_mode;
   logic                 do_push;
   logic                 do_pop;
   logic                 mode_q;
   logic                 push_mode;
   stk_op_e              stk_op;

   prio_irq_pend #(.NUM_LINES(NUM_LINES)) u_pend (
      .clk         (clk),
      .rst_n       (rst_n),
      .lines_i     (irq_lines),
      .swi_valid_i (swi_valid),
      .swi_num_i   (swi_num),
      .clr_valid_i (do_push),
      .clr_num_i   (irq_level),
      .pend_o      (pend_vec)
   );

   prio_irq_pick #(.NUM_LINES(NUM_LINES)) u_pick (
      .pend_i      (pend_vec),
      .thr_valid_i (~stk_empty),
      .thr_i       (top_lvl),
      .block_i     (stk_full),
      .any_o       (irq_req),
      .idx_o       (irq_level)
   );

   assign do_push = take & irq_req;
   assign do_pop  = eoi & ~stk_empty;

   always_comb begin
      unique case ({do_push, do_pop})
         2'b11:   stk_op = STK_SWAP;
         2'b10:   stk_op = STK_PUSH;
         2'b01:   stk_op = STK_POP;
         default: stk_op = STK_HOLD;
      endcase
   end

   // on a swap the entry keeps the mode that the pop restores
   assign push_mode = do_pop ? top_mode : mode_q;

   prio_irq_stack #(
      .NUM_LINES   (NUM_LINES),
      .STACK_DEPTH (STACK_DEPTH)
   ) u_stack (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_i       (stk_op),
      .lvl_i      (irq_level),
      .mode_i     (push_mode),
      .top_lvl_o  (top_lvl),
      .top_mode_o (top_mode),
      .empty_o    (stk_empty),
      .full_o     (stk_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       mode_q <= 1'b0;
      else if (do_push) mode_q <= 1'b1;
      else if (do_pop)  mode_q <= top_mode;
   end

   assign vec_addr    = base_addr + (ADDR_W'(irq_level) << VEC_SHIFT);
   assign ret_addr    = cur_pc + ADDR_W'(RET_STEP);
   assign mode_kernel = mode_q;
   assign svc_active  = ~stk_empty;
   assign svc_level   = top_lvl;

endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
   parameter int unsigned NUM_LINES = 32,
   localparam int unsigned LVL_W    = $clog2(NUM_LINES)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 take,
   input logic                 eoi,
   input logic                 irq_req,
   input logic [LVL_W-1:0]     irq_level,
   input logic                 svc_active,
   input logic [LVL_W-1:0]     svc_level,
   input logic                 mode_kernel,
   input logic [NUM_LINES-1:0] pend_vec
);

   assert_pick_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> pend_vec[irq_level]);

   assert_mask_above_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && svc_active) |-> (irq_level > svc_level));

   assert_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && irq_req) |=> (svc_active && mode_kernel && (svc_level == $past(irq_level))));

   assert_idle_eoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !svc_active && !take) |=> (!svc_active && $stable(mode_kernel)));

   assert_dead_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !irq_req && !eoi) |=>
         ($stable(svc_active) && $stable(svc_level) && $stable(mode_kernel)));

endmodule

bind prio_irq_ctrl prio_irq_chk #(.NUM_LINES(NUM_LINES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .take        (take),
   .eoi         (eoi),
   .irq_req     (irq_req),
   .irq_level   (irq_level),
   .svc_active  (svc_active),
   .svc_level   (svc_level),
   .mode_kernel (mode_kernel),
   .pend_vec    (pend_vec)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;

   localparam int N = 32;
   localparam int D = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] irq_lines;
   logic        swi_valid;
   logic [4:0]  swi_num;
   logic [31:0] base_addr;
   logic [31:0] cur_pc;
   logic        take;
   logic        eoi;
   logic        irq_req;
   logic [4:0]  irq_level;
   logic [31:0] vec_addr;
   logic [31:0] ret_addr;
   logic        mode_kernel;
   logic        svc_active;
   logic [4:0]  svc_level;

   always #2 clk = ~clk;

   prio_irq_ctrl u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_lines   (irq_lines),
      .swi_valid   (swi_valid),
      .swi_num     (swi_num),
      .base_addr   (base_addr),
      .cur_pc      (cur_pc),
      .take        (take),
      .eoi         (eoi),
      .irq_req     (irq_req),
      .irq_level   (irq_level),
      .vec_addr    (vec_addr),
      .ret_addr    (ret_addr),
      .mode_kernel (mode_kernel),
      .svc_active  (svc_active),
      .svc_level   (svc_level)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   // behavioural reference state
   bit [31:0] m_samp;
   bit [31:0] m_soft;
   int        m_lvl[$];
   bit        m_mstk[$];
   bit        m_mode;

   function automatic void m_comb(output bit req, output int lvl);
      int thr;
      thr = (m_lvl.size() > 0) ? m_lvl[$] : -1;
      req = 0;
      lvl = 0;
      if (m_lvl.size() < D) begin
         for (int i = N - 1; i >= 0; i--) begin
            if (!req && (m_samp[i] || m_soft[i]) && i > thr) begin
               req = 1;
               lvl = i;
            end
         end
      end
   endfunction

   task automatic check(input string ctx);
      bit req;
      int lvl;
      bit bad;
      bad = 0;
      m_comb(req, lvl);
      n_cmp++;
      if (irq_req !== req) begin
         bad = 1;
         $display("FAIL R3 %s: irq_req act=%0b exp=%0b", ctx, irq_req, req);
      end else if (req && irq_level !== 5'(lvl)) begin
         bad = 1;
         $display("FAIL R3 %s: irq_level act=%0d exp=%0d", ctx, irq_level, lvl);
      end
      if (req && vec_addr !== base_addr + 32'(lvl) * 32'd4) begin
         bad = 1;
         $display("FAIL R5 %s: vec_addr act=%h exp=%h", ctx, vec_addr,
                  base_addr + 32'(lvl) * 32'd4);
      end
      if (ret_addr !== cur_pc + 32'd4) begin
         bad = 1;
         $display("FAIL R6 %s: ret_addr act=%h exp=%h", ctx, ret_addr, cur_pc + 32'd4);
      end
      if (svc_active !== (m_lvl.size() > 0)) begin
         bad = 1;
         $display("FAIL R7 %s: svc_active act=%0b exp=%0b", ctx, svc_active,
                  m_lvl.size() > 0);
      end else if (m_lvl.size() > 0 && svc_level !== 5'(m_lvl[$])) begin
         bad = 1;
         $display("FAIL R7 %s: svc_level act=%0d exp=%0d", ctx, svc_level, m_lvl[$]);
      end
      if (mode_kernel !== m_mode) begin
         bad = 1;
         $display("FAIL R8 %s: mode_kernel act=%0b exp=%0b", ctx, mode_kernel, m_mode);
      end
      if (bad) n_bad++;
   endtask

   // inputs are already set; advance one clock in model and design, then compare
   task automatic step(input string ctx);
      bit req;
      int lvl;
      m_comb(req, lvl);
      if (eoi && m_lvl.size() > 0) begin
         m_mode = m_mstk.pop_back();
         void'(m_lvl.pop_back());
      end
      if (take && req) begin
         m_mstk.push_back(m_mode);
         m_lvl.push_back(lvl);
         m_mode = 1;
         m_soft[lvl] = 0;
      end
      if (swi_valid) m_soft[swi_num] = 1;
      m_samp = irq_lines;
      @(negedge clk);
      check(ctx);
   endtask

   task automatic idle_inputs();
      take      = 0;
      eoi       = 0;
      swi_valid = 0;
      swi_num   = '0;
   endtask

   initial begin
      rst_n     = 0;
      irq_lines = '0;
      base_addr = 32'h0000_1000;
      cur_pc    = 32'h0000_0400;
      idle_inputs();
      m_samp = '0; m_soft = '0; m_mode = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      check("R1 reset state");

      // R2 line 10 sampled, presented next cycle; R5 vector 0x1028
      irq_lines[10] = 1;
      step("R2 line sampled");
      // R7 enter level 10; line held but masked at equal level (R4)
      take = 1;
      step("R7 take 10");
      take = 0;
      step("R4 equal level masked");
      // R4 lower level 5 masked, 28 (clock tick) preempts
      irq_lines[5]  = 1;
      irq_lines[28] = 1;
      step("R4 lower masked");
      take = 1;
      step("R7 nest 28");
      take = 0;
      // R11 software request for level 29
      swi_valid = 1; swi_num = 5'd29;
      step("R11 swi set");
      swi_valid = 0;
      irq_lines[30] = 1;
      take = 1;
      step("R11 swi taken");
      step("R7 nest 30");
      take = 0;
      // R7 depth 4 reached: line 31 not presented
      irq_lines[31] = 1;
      step("R7 full stack");
      step("R7 full stack hold");
      // R8 pop 30, 31 now presented above 29
      eoi = 1;
      step("R8 eoi pops");
      // R12 take and eoi together: 29 replaced by 31
      take = 1;
      step("R12 swap");
      take = 0; eoi = 0;
      step("R12 after swap");
      // R2 masked line 5 still held: appears once levels retire
      irq_lines[31] = 0; irq_lines[30] = 0; irq_lines[28] = 0; irq_lines[10] = 0;
      eoi = 1;
      repeat (4) step("R8 unwind");
      // R9 eoi with empty stack
      step("R9 idle eoi");
      eoi = 0;
      irq_lines = '0;
      step("R2 drop lines");
      // R10 take with nothing presented
      take = 1;
      step("R10 dead take");
      take = 0;
      // R11 swi set while same level taken: new request kept
      swi_valid = 1; swi_num = 5'd2;
      step("R11 swi level 2");
      take = 1;
      step("R11 take and reraise");
      swi_valid = 0; take = 0;
      step("R11 still pending");
      eoi = 1;
      step("R8 pop 2");
      eoi = 0;

      // random phase
      for (int k = 0; k < 4000; k++) begin
         irq_lines = $urandom & $urandom & $urandom;
         take      = ($urandom % 2) == 0;
         eoi       = ($urandom % 4) == 0;
         swi_valid = ($urandom % 8) == 0;
         swi_num   = 5'($urandom);
         base_addr = $urandom;
         cur_pc    = $urandom;
         step("random");
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete act=hung exp=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule